// File: doc/BRIEF.md
# Packed Double Horizontal Adder

This block adds neighbouring pairs of IEEE-754 double-precision values that sit inside the same source vector. Each of the two 256-bit sources holds four doubles, called elements 0 to 3 from the least significant end. Lane 0 of the result is the sum of the two low elements of the first source. Lane 1 is the sum of the two low elements of the second source. In wide operation, lane 2 is the sum of the two high elements of the first source and lane 3 is the sum of the two high elements of the second source. Every lane has its own adder, which rounds to nearest with ties to even and handles zeros, subnormals, infinities and NaNs.

A 2-bit mode selects what happens to the upper 128 result bits. The merge mode keeps them from the first source, which in that mode is also the destination register. The clear modes zero them. The wide mode computes them. In merge mode the second operand may come from memory. If that operand's address is not a multiple of 16 bytes, a protection fault is reported and no result or flags are produced. Five exception flags are reported for each operation. They are also accumulated in a sticky register that only reset clears. The block has one register stage, so results, flags and the fault appear one clock after the operation is accepted.

Top module: `hadd_unit`

## Requirements
- R1: When `in_valid` is sampled high at a rising edge, `out_valid` is high after that edge, and otherwise it is low. After such an operation, `result[63:0]` is src1 element 0 plus src1 element 1, and `result[127:64]` is src2 element 0 plus src2 element 1.
- R2: With `mode` = 2'b10 (wide), `result[191:128]` is src1 element 2 plus element 3, and `result[255:192]` is src2 element 2 plus element 3.
- R3: With `mode` = 2'b00 (merge), `result[255:128]` equals `src1[255:128]` unchanged.
- R4: With `mode` = 2'b01 or 2'b11 (clear), `result[255:128]` is all zeros.
- R5: Sums of finite operands, normal or subnormal, are rounded to nearest with ties to even. The inexact flag is set when the rounded sum differs from the exact sum.
- R6: Infinity plus a finite value, or plus an infinity of the same sign, returns that infinity with no flag. Infinities of opposite sign return 64'hFFF8000000000000 and set invalid.
- R7: A NaN operand is returned with fraction bit 51 set. If both operands are NaN, the lower-indexed element is returned. A signalling NaN (fraction bit 51 clear) sets invalid. A quiet NaN sets no flag.
- R8: The per-operation `flags` are bit 0 invalid, bit 1 denormal operand, bit 2 overflow, bit 3 underflow and bit 4 inexact. Each flag is the OR over the active lanes only: lanes 0 and 1, plus lanes 2 and 3 in wide mode.
- R9: A finite sum whose rounded magnitude exceeds the largest double returns a signed infinity and sets both overflow and inexact. Underflow is set only for a result below the normal range that is also inexact.
- R10: The denormal flag is set whenever either operand of an active lane is subnormal.
- R11: In merge mode, with `src2_mem` high and `src2_addr[3:0]` nonzero, `gp_fault` is 1, `result` is zero, `flags` are zero and `sticky` is unchanged. In any other mode, or with an aligned address, `gp_fault` is 0.
- R12: `sticky` is the OR of the `flags` of every operation since reset, and reset clears it.
- R13: During and right after reset, all outputs are zero. A cycle without `in_valid` drives `out_valid` low and leaves `result`, `flags`, `gp_fault` and `sticky` unchanged.
- R14: An exact zero sum is +0, unless both operands are -0, in which case it is -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the source inputs |
| mode | input | 2 | 00 merge, 01/11 clear upper half, 10 wide |
| src1 | input | 256 | First source; in merge mode also the old destination |
| src2 | input | 256 | Second source |
| src2_mem | input | 1 | Second source was read from memory |
| src2_addr | input | ADDR_W | Byte address of the memory operand |
| out_valid | output | 1 | Result of an accepted operation is present |
| result | output | 256 | Four packed double sums |
| flags | output | 5 | Exception flags of the last operation |
| sticky | output | 5 | Accumulated exception flags since reset |
| gp_fault | output | 1 | Misaligned memory operand in merge mode |

## Verification
Every lane datapath fault surfaces in the result bits one clock after the operation is accepted. It can therefore be caught by comparing the result against a behavioural reference on the very next cycle. A wrong guard, round or sticky bit inside a lane adder shows only as a one-ulp error or a wrong inexact flag. For that reason, ties, cancellation and exponent-gap cases are mixed into the stimulus. A corrupted sticky register persists across all later operations and is visible on every clock until reset, while a bad mode decode shows at once in the upper half.

// File: rtl/hadd_pkg.sv
package hadd_pkg;

    localparam int FP_W    = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int XTRA_W  = 3;
    localparam int WORK_W  = MANT_W + XTRA_W;
    localparam int LZ_W    = $clog2(WORK_W + 1);
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int EW      = EXP_W + 2;
    localparam int LANES   = 4;
    localparam int VEC_W   = LANES * FP_W;
    localparam int HALF_W  = VEC_W / 2;
    localparam int FLAG_W  = 5;

    localparam logic [FP_W-1:0] DEFAULT_NAN = 64'hFFF8_0000_0000_0000;
    localparam logic [FP_W-1:0] QUIET_MASK  = 64'h0008_0000_0000_0000;

    typedef enum logic [1:0] {
        MODE_MERGE = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_WIDE  = 2'b10,
        MODE_CLR_B = 2'b11
    } hadd_mode_e;

    // bit 0 invalid .. bit 4 inexact
    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic denormal;
        logic invalid;
    } fp_flags_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp64_t;

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
    } fp_class_e;

    function automatic fp_class_e classify(input fp64_t v);
        if (v.exp == '1)
            return (v.frac == '0) ? CLS_INF :
                   (v.frac[FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
        if (v.exp == '0)
            return (v.frac == '0) ? CLS_ZERO : CLS_SUB;
        return CLS_NORM;
    endfunction

    function automatic logic is_nan(input fp_class_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic [FP_W-1:0] quieten(input fp64_t v);
        return v | QUIET_MASK;
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [WORK_W-1:0] v);
        logic [LZ_W-1:0] n;
        n = LZ_W'(WORK_W);
        for (int i = 0; i < WORK_W; i++)
            if (v[i]) n = LZ_W'(WORK_W - 1 - i);
        return n;
    endfunction

    function automatic logic mode_is_wide(input logic [1:0] m);
        return m == MODE_WIDE;
    endfunction

endpackage

// File: rtl/hadd_dp_add.sv
module hadd_dp_add
    import hadd_pkg::*;
(
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic [FP_W-1:0] sum,
    output fp_flags_t       flg
);
    fp64_t             fa, fb, big, sml;
    fp_class_e         ca, cb;
    logic [MANT_W-1:0] m_big, m_sml;
    logic [EW-1:0]     e_big, e_sml, diff, e_n, e_r, lsh;
    logic [WORK_W-1:0] w_big, w_sml, w_sh, nrm;
    logic [WORK_W:0]   raw;
    logic [LZ_W-1:0]   lz;
    logic [MANT_W:0]   rnd;
    logic              swap, eff_sub, lost, guard, rest, inc, tiny, inexact, ovf;
    logic [FP_W-1:0]   fin;

    always_comb begin
        fa = op_a;
        fb = op_b;
        ca = classify(fa);
        cb = classify(fb);

        // order by magnitude
        swap  = {fb.exp, fb.frac} > {fa.exp, fa.frac};
        big   = swap ? fb : fa;
        sml   = swap ? fa : fb;
        m_big = {big.exp != '0, big.frac};
        m_sml = {sml.exp != '0, sml.frac};
        e_big = (big.exp == '0) ? EW'(1) : {2'b00, big.exp};
        e_sml = (sml.exp == '0) ? EW'(1) : {2'b00, sml.exp};
        diff  = e_big - e_sml;

        // align with guard/round/sticky
        w_big = {m_big, {XTRA_W{1'b0}}};
        w_sml = {m_sml, {XTRA_W{1'b0}}};
        if (diff >= EW'(WORK_W)) begin
            w_sh = '0;
            lost = |w_sml;
        end else begin
            w_sh = w_sml >> diff;
            lost = (w_sh << diff) != w_sml;
        end
        w_sh[0] = w_sh[0] | lost;

        eff_sub = big.sign ^ sml.sign;
        raw = eff_sub ? ({1'b0, w_big} - {1'b0, w_sh})
                      : ({1'b0, w_big} + {1'b0, w_sh});

        // normalise
        lz  = '0;
        lsh = '0;
        if (raw[WORK_W]) begin
            nrm    = raw[WORK_W:1];
            nrm[0] = raw[1] | raw[0];
            e_n    = e_big + EW'(1);
        end else begin
            lz  = lead_zeros(raw[WORK_W-1:0]);
            lsh = ({{(EW-LZ_W){1'b0}}, lz} > (e_big - EW'(1))) ?
                  (e_big - EW'(1)) : {{(EW-LZ_W){1'b0}}, lz};
            nrm = raw[WORK_W-1:0] << lsh;
            e_n = e_big - lsh;
        end

        // round to nearest even
        tiny    = ~nrm[WORK_W-1];
        guard   = nrm[XTRA_W-1];
        rest    = |nrm[XTRA_W-2:0];
        inexact = guard | rest;
        inc     = guard & (rest | nrm[XTRA_W]);
        rnd     = {1'b0, nrm[WORK_W-1:XTRA_W]} + {{MANT_W{1'b0}}, inc};
        e_r     = e_n;
        if (rnd[MANT_W]) begin
            rnd = rnd >> 1;
            e_r = e_n + EW'(1);
        end
        ovf = e_r >= EW'(EXP_MAX);

        if (raw == '0)
            fin = {big.sign & sml.sign, {(FP_W-1){1'b0}}};
        else if (ovf)
            fin = {big.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            fin = {big.sign, rnd[MANT_W-1] ? e_r[EXP_W-1:0] : {EXP_W{1'b0}},
                   rnd[FRAC_W-1:0]};

        // special operands
        flg          = '0;
        flg.denormal = (ca == CLS_SUB) || (cb == CLS_SUB);
        if (is_nan(ca) || is_nan(cb)) begin
            sum         = is_nan(ca) ? quieten(fa) : quieten(fb);
            flg.invalid = (ca == CLS_SNAN) || (cb == CLS_SNAN);
        end else if (ca == CLS_INF && cb == CLS_INF && fa.sign != fb.sign) begin
            sum         = DEFAULT_NAN;
            flg.invalid = 1'b1;
        end else if (ca == CLS_INF) begin
            sum = op_a;
        end else if (cb == CLS_INF) begin
            sum = op_b;
        end else begin
            sum           = fin;
            flg.overflow  = ovf;
            flg.inexact   = inexact | ovf;
            flg.underflow = tiny & inexact & (raw != '0);
        end
    end

endmodule

// File: rtl/hadd_lane_array.sv
module hadd_lane_array
    import hadd_pkg::*;
(
    input  logic [VEC_W-1:0] src1,
    input  logic [VEC_W-1:0] src2,
    input  logic             wide,
    output logic [VEC_W-1:0] sums,
    output fp_flags_t        flags_or
);
    fp_flags_t lane_flg [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = (k / 2) * 2;
        logic [FP_W-1:0] el_lo, el_hi;
        if (k % 2 == 0) begin : g_s1
            assign el_lo = src1[LO*FP_W +: FP_W];
            assign el_hi = src1[(LO+1)*FP_W +: FP_W];
        end else begin : g_s2
            assign el_lo = src2[LO*FP_W +: FP_W];
            assign el_hi = src2[(LO+1)*FP_W +: FP_W];
        end
        hadd_dp_add u_add (
            .op_a (el_lo),
            .op_b (el_hi),
            .sum  (sums[k*FP_W +: FP_W]),
            .flg  (lane_flg[k])
        );
    end

    always_comb begin
        flags_or = '0;
        for (int k = 0; k < LANES; k++)
            if (k < LANES / 2 || wide)
                flags_or = flags_or | lane_flg[k];
    end

endmodule

// File: rtl/hadd_out_reg.sv
module hadd_out_reg
    import hadd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             fault,
    input  logic [VEC_W-1:0] data,
    input  fp_flags_t        op_flags,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output fp_flags_t        flags_q,
    output fp_flags_t        sticky_q,
    output logic             fault_q
);
    fp_flags_t eff_flags;

    always_comb eff_flags = fault ? '0 : op_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
            sticky_q  <= '0;
            fault_q   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= fault ? '0 : data;
                flags_q  <= eff_flags;
                sticky_q <= sticky_q | eff_flags;
                fault_q  <= fault;
            end
        end
    end

endmodule

// File: rtl/hadd_unit.sv
module hadd_unit
    import hadd_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [VEC_W-1:0]  src1,
    input  logic [VEC_W-1:0]  src2,
    input  logic              src2_mem,
    input  logic [ADDR_W-1:0] src2_addr,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] sticky,
    output logic              gp_fault
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(ALIGN_BYTES - 1);

    logic              wide, fault;
    logic [VEC_W-1:0]  sums, merged;
    fp_flags_t         op_flags, flags_q, sticky_q;

    assign wide  = mode_is_wide(mode);
    assign fault = (mode == MODE_MERGE) && src2_mem &&
                   ((src2_addr & ALIGN_MASK) != '0);

    hadd_lane_array u_lanes (
        .src1     (src1),
        .src2     (src2),
        .wide     (wide),
        .sums     (sums),
        .flags_or (op_flags)
    );

    always_comb begin
        merged[HALF_W-1:0] = sums[HALF_W-1:0];
        unique case (mode)
            MODE_MERGE: merged[VEC_W-1:HALF_W] = src1[VEC_W-1:HALF_W];
            MODE_WIDE:  merged[VEC_W-1:HALF_W] = sums[VEC_W-1:HALF_W];
            default:    merged[VEC_W-1:HALF_W] = '0;
        endcase
    end

    hadd_out_reg u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .fault     (fault),
        .data      (merged),
        .op_flags  (op_flags),
        .out_valid (out_valid),
        .result    (result),
        .flags_q   (flags_q),
        .sticky_q  (sticky_q),
        .fault_q   (gp_fault)
    );

    assign flags  = flags_q;
    assign sticky = sticky_q;

endmodule

// File: rtl/hadd_unit_chk.sv
module hadd_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   mode,
    input logic [127:0] src1_hi,
    input logic         out_valid,
    input logic [255:0] result,
    input logic [4:0]   flags,
    input logic [4:0]   sticky,
    input logic         gp_fault
);
    // R1: one-cycle valid latency
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R3: merge mode keeps the old upper half
    a_r3_merge_upper: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !gp_fault && $past(mode) == 2'b00) |->
        (result[255:128] == $past(src1_hi)));

    // R4: clear modes zero the upper half
    a_r4_clear_upper: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode[0])) |-> (result[255:128] == '0));

    // R11: a fault blanks result and flags
    a_r11_fault_blank: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> (result == '0 && flags == '0));

    // R11: no fault outside merge mode
    a_r11_merge_only: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode) != 2'b00) |-> !gp_fault);

    // R12: sticky bits never clear without reset
    a_r12_sticky_keep: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(sticky) & ~sticky) == '0));

    // R12: sticky covers the current flags
    a_r12_sticky_cover: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((flags & ~sticky) == '0));
endmodule

bind hadd_unit hadd_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .src1_hi   (src1[255:128]),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags),
    .sticky    (sticky),
    .gp_fault  (gp_fault)
);

// File: tb/hadd_unit_bench.sv
module hadd_unit_bench;
    localparam int AW = 48;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [1:0]     mode = 2'b00;
    logic [255:0]   src1 = '0, src2 = '0;
    logic           src2_mem = 1'b0;
    logic [AW-1:0]  src2_addr = '0;
    logic           out_valid, gp_fault;
    logic [255:0]   result;
    logic [4:0]     flags, sticky;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // expected state
    logic         e_valid = 0, e_fault = 0;
    logic [255:0] e_res = '0;
    logic [4:0]   e_flags = '0, e_sticky = '0;
    string        up_tag = "R13";

    always #5 clk = ~clk;

    hadd_unit #(.ADDR_W(AW)) u_hadd_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .src1(src1), .src2(src2), .src2_mem(src2_mem), .src2_addr(src2_addr),
        .out_valid(out_valid), .result(result), .flags(flags),
        .sticky(sticky), .gp_fault(gp_fault)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit nan64(input logic [63:0] v);
        return v[62:52] == 11'h7FF && v[51:0] != 0;
    endfunction
    function automatic bit inf64(input logic [63:0] v);
        return v[62:52] == 11'h7FF && v[51:0] == 0;
    endfunction

    // behavioural reference: simulator doubles plus special rules
    task automatic ref_add(input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] s, output logic [4:0] f);
        real x, y, r, bv, av, err;
        f = '0;
        f[1] = (a[62:52] == 0 && a[51:0] != 0) || (b[62:52] == 0 && b[51:0] != 0);
        if (nan64(a) || nan64(b)) begin
            s = nan64(a) ? (a | 64'h0008_0000_0000_0000) : (b | 64'h0008_0000_0000_0000);
            f[0] = (nan64(a) && !a[51]) || (nan64(b) && !b[51]);
        end else if (inf64(a) && inf64(b) && a[63] != b[63]) begin
            s = 64'hFFF8_0000_0000_0000;
            f[0] = 1;
        end else begin
            x = $bitstoreal(a); y = $bitstoreal(b);
            r = x + y;
            s = $realtobits(r);
            if (!inf64(a) && !inf64(b)) begin
                if (inf64(s)) begin
                    f[2] = 1; f[4] = 1;
                end else begin
                    bv = r - x; av = r - bv; err = (x - av) + (y - bv);
                    f[4] = (err != 0.0);
                end
            end
        end
    endtask

    task automatic model_update();
        logic [63:0] s;
        logic [4:0]  f;
        e_valid = in_valid;
        if (in_valid) begin
            e_fault = (mode == 2'b00) && src2_mem && (src2_addr[3:0] != 0);
            e_res = '0; e_flags = '0;
            if (e_fault) begin
                up_tag = "R11";
            end else begin
                ref_add(src1[63:0], src1[127:64], s, f);   e_res[63:0]   = s; e_flags |= f;
                ref_add(src2[63:0], src2[127:64], s, f);   e_res[127:64] = s; e_flags |= f;
                if (mode == 2'b10) begin
                    ref_add(src1[191:128], src1[255:192], s, f); e_res[191:128] = s; e_flags |= f;
                    ref_add(src2[191:128], src2[255:192], s, f); e_res[255:192] = s; e_flags |= f;
                    up_tag = "R2";
                end else if (mode == 2'b00) begin
                    e_res[255:128] = src1[255:128];
                    up_tag = "R3";
                end else begin
                    up_tag = "R4";
                end
            end
            e_sticky |= e_flags;
        end
    endtask

    // drive at a falling edge, model at the rising edge, compare at the next fall
    task automatic step(input logic v, input logic [1:0] m, input logic [255:0] s1,
                        input logic [255:0] s2, input logic mem, input logic [AW-1:0] ad,
                        input string rtag, input string ftag);
        in_valid = v; mode = m; src1 = s1; src2 = s2; src2_mem = mem; src2_addr = ad;
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(v ? "R1" : "R13", {255'b0, out_valid}, {255'b0, e_valid});
        chk(rtag, {128'b0, result[127:0]}, {128'b0, e_res[127:0]});
        chk(up_tag, {128'b0, result[255:128]}, {128'b0, e_res[255:128]});
        chk(ftag, {251'b0, flags}, {251'b0, e_flags});
        chk("R11", {255'b0, gp_fault}, {255'b0, e_fault});
        chk("R12", {251'b0, sticky}, {251'b0, e_sticky});
    endtask

    function automatic logic [63:0] rnd_norm();
        logic [63:0] v;
        v = {$urandom, $urandom};
        v[62:52] = 11'd1000 + 11'($urandom % 47);
        return v;
    endfunction

    function automatic logic [255:0] pk(input logic [63:0] e0, input logic [63:0] e1,
                                        input logic [63:0] e2, input logic [63:0] e3);
        return {e3, e2, e1, e0};
    endfunction

    // pair placed in lane 0 as given, in lane 1 reversed, normals above
    task automatic pair(input logic [63:0] lo, input logic [63:0] hi, input string tag);
        step(1, 2'b10, pk(lo, hi, rnd_norm(), rnd_norm()),
             pk(hi, lo, rnd_norm(), rnd_norm()), 0, '0, tag, tag);
    endtask

    task automatic reset_check();
        rst = 1; in_valid = 0;
        repeat (3) @(negedge clk);
        e_valid = 0; e_res = '0; e_flags = '0; e_sticky = '0; e_fault = 0;
        chk("R13", {255'b0, out_valid}, '0);
        chk("R13", result, '0);
        chk("R13", {246'b0, flags, sticky}, '0);
        chk("R13", {255'b0, gp_fault}, '0);
        rst = 0;
    endtask

    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] MAXN = 64'h7FEF_FFFF_FFFF_FFFF;

    initial begin
        logic [63:0] a, b;
        reset_check();

        // random normals, wide mode, with cancellation mix
        for (int i = 0; i < 60; i++) begin
            a = rnd_norm(); b = rnd_norm();
            if (i % 3 == 0) begin b = a ^ 64'h8000_0000_0000_0000; b[7:0] = 8'($urandom); end
            if (i % 3 == 1) b[62:52] = a[62:52] - 11'($urandom % 3);
            step(1, 2'b10, pk(a, b, rnd_norm(), rnd_norm()),
                 pk(rnd_norm(), rnd_norm(), b, a), 0, '0, "R5", "R8");
            if (i % 7 == 0) step(0, 2'b01, '0, '0, 0, '0, "R13", "R13");
        end
        // merge and clear modes
        for (int i = 0; i < 15; i++)
            step(1, 2'b00, pk(rnd_norm(), rnd_norm(), rnd_norm(), rnd_norm()),
                 pk(rnd_norm(), rnd_norm(), rnd_norm(), rnd_norm()), 0, '0, "R1", "R8");
        for (int i = 0; i < 15; i++)
            step(1, (i % 2) ? 2'b11 : 2'b01, pk(rnd_norm(), rnd_norm(), rnd_norm(), rnd_norm()),
                 pk(rnd_norm(), rnd_norm(), rnd_norm(), rnd_norm()), 0, '0, "R1", "R8");

        // rounding ties
        pair(ONE, 64'h3CA0_0000_0000_0000, "R5");
        pair(64'h3FF0_0000_0000_0001, 64'h3CA0_0000_0000_0000, "R5");
        pair(64'h3FF0_0000_0000_0001, 64'hBCA0_0000_0000_0000, "R5");
        // infinities
        pair(PINF, NINF, "R6");
        pair(PINF, ONE, "R6");
        pair(NINF, NINF, "R6");
        // NaNs
        pair(64'h7FF0_0000_0000_0001, ONE, "R7");
        pair(64'h7FF8_0000_0000_0005, ONE, "R7");
        pair(64'hFFF8_0000_0000_0007, 64'h7FF0_0000_0000_0009, "R7");
        // overflow and subnormals
        pair(MAXN, MAXN, "R9");
        pair(MAXN ^ 64'h8000_0000_0000_0000, 64'hFCA0_0000_0000_0000, "R9");
        pair(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, "R10");
        pair(64'h000F_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R10");
        pair(64'h0010_0000_0000_0000, 64'h8000_0000_0000_0001, "R10");
        // signed zeros
        pair(64'h0, 64'h8000_0000_0000_0000, "R14");
        pair(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R14");
        pair(ONE, ONE ^ 64'h8000_0000_0000_0000, "R14");

        // inactive upper lanes raise no flags (R8)
        reset_check();
        step(1, 2'b01, pk(ONE, ONE, PINF, NINF), pk(ONE, ONE, 64'h7FF0_0000_0000_0001, ONE),
             0, '0, "R8", "R8");
        step(1, 2'b00, pk(ONE, ONE, PINF, NINF), pk(ONE, ONE, MAXN, MAXN), 0, '0, "R8", "R8");

        // alignment fault (R11)
        step(1, 2'b10, pk(PINF, NINF, ONE, ONE), pk(ONE, ONE, ONE, ONE), 1, 48'h1008, "R11", "R11");
        step(1, 2'b00, pk(PINF, NINF, ONE, ONE), pk(ONE, ONE, ONE, ONE), 1, 48'h1008, "R11", "R11");
        step(0, 2'b00, '0, '0, 0, '0, "R13", "R13");
        step(1, 2'b00, pk(ONE, 64'h3CA0_0000_0000_0000, ONE, ONE), pk(ONE, ONE, ONE, ONE),
             1, 48'h1030, "R11", "R11");
        step(1, 2'b01, pk(ONE, ONE, ONE, ONE), pk(ONE, ONE, ONE, ONE), 1, 48'h1001, "R11", "R11");
        step(1, 2'b00, pk(ONE, ONE, ONE, ONE), pk(MAXN, MAXN, ONE, ONE), 1, 48'h0004, "R11", "R11");
        step(1, 2'b00, pk(ONE, ONE, ONE, ONE), pk(MAXN, MAXN, ONE, ONE), 0, 48'h0004, "R11", "R12");

        // reset clears sticky (R12)
        reset_check();
        step(0, 2'b00, '0, '0, 0, '0, "R12", "R12");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule